// File: doc/BRIEF.md
# Seven-to-one serial pixel link receiver

This block recovers parallel pixels from a seven-bit-per-pixel serial display link. Four data lanes and the link's clock lane arrive as single-ended bit streams, already sampled once per bit period on a local bit-rate clock. The block holds a seven-bit history of every lane. It watches the clock lane to find where each pixel begins, and once it is aligned it unpacks the histories into 8-bit red, green and blue values plus horizontal sync, vertical sync and data enable.

Three lane mappings are supported. One is an 18-bit mapping that uses only three lanes. The other two are 24-bit mappings that differ in whether lane 3 carries the least or the most significant colour bits. A pixel is presented with a one-cycle valid strobe every seven bit periods, and only while the receiver reports lock. A sticky flag records a set spare control bit in the 24-bit mappings.

Top module: `lvds_deser`

## Requirements
- R1: While reset is asserted, and directly after it, `locked`, `pixValid`, `ctlErr`, the sync and enable outputs and all colour outputs are 0.
- R2: The clock lane carries 1,1,0,0,0,1,1 in slots 0 to 6, and slot 0 is received first on every lane. Lock is declared when this pattern has been seen aligned on LOCK_COUNT (4) consecutive pixel periods. The first valid pixel is the one that completed the fourth aligned pattern.
- R3: `pixValid` is high for exactly one cycle per pixel period while locked and is never high while unlocked.
- R4: One pixel period with a clock-lane mismatch keeps lock, and that pixel is still strobed. DROP_COUNT (2) consecutive mismatches clear lock, and no pixel is strobed for the second one. After that, lock needs LOCK_COUNT fresh aligned periods.
- R5: `mapSel` = 00 selects the 18-bit mapping. Lane 0 carries G0,R5,R4,R3,R2,R1,R0; lane 1 carries B1,B0,G5..G1; lane 2 carries DE,VS,HS,B5..B2, each list in slot order 0 to 6. Colour bits 7 and 6 read 0, and lane 3 has no effect.
- R6: `mapSel` = 01 selects the 24-bit mapping in which lanes 0 to 2 carry colour bits 7..2, laid out as in R5 with every index raised by 2. Lane 3 carries CTL3,B1,B0,G1,G0,R1,R0.
- R7: `mapSel` = 10 or 11 selects the 24-bit mapping in which lanes 0 to 2 carry bits 5..0 as in R5. Lane 3 carries CTL3,B7,B6,G7,G6,R7,R6.
- R8: The three control slots on lane 2 decode as `dataEn` (slot 0), `vSync` (slot 1) and `hSync` (slot 2).
- R9: `ctlErr` is set when a strobed pixel in either 24-bit mapping has CTL3 = 1, and it stays set until reset. Lane 3 content in the 18-bit mapping, and CTL3 on pixels that are not strobed, leave it clear.
- R10: While unlocked, a match found at a bit offset that differs from the current pixel phase re-times the pixel phase to that offset. It counts as the first of the LOCK_COUNT aligned periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dataLanes | input | 4 | Sampled data lanes, bit n is lane n |
| clkLane | input | 1 | Sampled clock lane |
| mapSel | input | 2 | Lane mapping select (R5 to R7) |
| red | output | 8 | Red component of the last pixel |
| green | output | 8 | Green component of the last pixel |
| blue | output | 8 | Blue component of the last pixel |
| hSync | output | 1 | Horizontal sync of the last pixel |
| vSync | output | 1 | Vertical sync of the last pixel |
| dataEn | output | 1 | Data enable of the last pixel |
| pixValid | output | 1 | One-cycle strobe for a new pixel |
| locked | output | 1 | Clock-lane alignment achieved |
| ctlErr | output | 1 | Sticky flag for a set spare control bit |

## Verification
The assertions take for granted that `mapSel` does not change within a pixel period. The narrow-mapping check compares the outputs with the select value sampled on the load edge. They also take for granted that all lanes share one bit alignment, because skew between lanes is not corrected. The stimulus meets both conditions: the mapping is set only while reset is held, and every lane of a pixel is driven in the same cycle from one encoder task. Misalignment is introduced only on purpose, by inserting whole idle bits on every lane at once.

// File: rtl/lvds_deser_pkg.sv
package lvds_deser_pkg;
  localparam int SLOTS   = 7;
  localparam int LANES   = 4;
  localparam int COLOR_W = 8;
  localparam int PHASE_W = $clog2(SLOTS);
  // Clock-lane value with bit (6 - slot) holding slot 'slot' once a pixel is complete.
  localparam logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011;

  localparam logic [1:0] MAP_NARROW     = 2'b00;
  localparam logic [1:0] MAP_WIDE_SPLIT = 2'b01;

  typedef struct packed {
    logic sample; // pixel boundary: load the unpacked fields
    logic emit;   // boundary while locked: strobe the pixel
  } ctlStrobes_t;
endpackage

// File: rtl/lvds_deser_ctrl.sv
module lvds_deser_ctrl
  import lvds_deser_pkg::*;
#(
  parameter int LOCK_COUNT = 4,
  parameter int DROP_COUNT = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        patternMatch,
  output ctlStrobes_t strobes,
  output logic        locked
);
  localparam int GOOD_W = $clog2(LOCK_COUNT + 1);
  localparam int BAD_W  = $clog2(DROP_COUNT + 1);

  logic [PHASE_W-1:0] phase, phaseNext;
  logic [GOOD_W-1:0]  goodCnt, goodNext;
  logic [BAD_W-1:0]   badCnt, badNext;
  logic               lockedNext;
  logic               atBoundary;

  assign atBoundary = (phase == PHASE_W'(SLOTS - 1));

  always_comb begin
    phaseNext  = atBoundary ? '0 : phase + PHASE_W'(1);
    goodNext   = goodCnt;
    badNext    = badCnt;
    lockedNext = locked;
    if (!locked) begin
      if (atBoundary) begin
        if (patternMatch) begin
          if (goodCnt >= GOOD_W'(LOCK_COUNT - 1)) begin
            lockedNext = 1'b1;
            goodNext   = '0;
          end else begin
            goodNext = goodCnt + GOOD_W'(1);
          end
        end else begin
          goodNext = '0;
        end
      end else if (patternMatch) begin
        // Pattern seen at another offset: the bit taken now is slot 0.
        phaseNext = '0;
        goodNext  = GOOD_W'(1);
      end
    end else if (atBoundary) begin
      if (patternMatch) begin
        badNext = '0;
      end else if (badCnt >= BAD_W'(DROP_COUNT - 1)) begin
        lockedNext = 1'b0;
        badNext    = '0;
        goodNext   = '0;
      end else begin
        badNext = badCnt + BAD_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= '0;
      goodCnt <= '0;
      badCnt  <= '0;
      locked  <= 1'b0;
    end else begin
      phase   <= phaseNext;
      goodCnt <= goodNext;
      badCnt  <= badNext;
      locked  <= lockedNext;
    end
  end

  assign strobes.sample = atBoundary;
  assign strobes.emit   = atBoundary & lockedNext;

  AST_LOCK_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(patternMatch)); // R2
  AST_UNLOCK_AFTER_MISS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> !$past(patternMatch)); // R4
  AST_REALIGN_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && patternMatch && !atBoundary) |=> (phase == '0) && !locked); // R10
endmodule

// File: rtl/lvds_deser_dp.sv
module lvds_deser_dp
  import lvds_deser_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [LANES-1:0]   dataLanes,
  input  logic               clkLane,
  input  logic [1:0]         mapSel,
  input  ctlStrobes_t        strobes,
  output logic               patternMatch,
  output logic [COLOR_W-1:0] red,
  output logic [COLOR_W-1:0] green,
  output logic [COLOR_W-1:0] blue,
  output logic               hSync,
  output logic               vSync,
  output logic               dataEn,
  output logic               pixValid,
  output logic               ctlErr
);
  localparam int HI_W = COLOR_W - 2;

  logic [LANES-1:0][SLOTS-1:0] laneHist;
  logic [SLOTS-1:0]            clkHist;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [SLOTS-1:0] hist;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) hist <= '0;
      else       hist <= {hist[SLOTS-2:0], dataLanes[ln]};
    end
    assign laneHist[ln] = hist;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkHist <= '0;
    else       clkHist <= {clkHist[SLOTS-2:0], clkLane};
  end

  assign patternMatch = (clkHist == CLK_PATTERN);

  // Field extraction; bit (6 - s) of a history holds slot s.
  logic [HI_W-1:0] rSix, gSix, bSix;
  logic [1:0]      rPair, gPair, bPair;
  logic            deBit, vsBit, hsBit, spareBit, wideMode;

  assign rSix     = laneHist[0][5:0];
  assign gSix     = {laneHist[1][4:0], laneHist[0][6]};
  assign bSix     = {laneHist[2][3:0], laneHist[1][6:5]};
  assign deBit    = laneHist[2][6];
  assign vsBit    = laneHist[2][5];
  assign hsBit    = laneHist[2][4];
  assign spareBit = laneHist[3][6];
  assign bPair    = laneHist[3][5:4];
  assign gPair    = laneHist[3][3:2];
  assign rPair    = laneHist[3][1:0];
  assign wideMode = (mapSel != MAP_NARROW);

  logic [COLOR_W-1:0] rNext, gNext, bNext;

  always_comb begin
    if (!wideMode) begin
      rNext = {2'b00, rSix};
      gNext = {2'b00, gSix};
      bNext = {2'b00, bSix};
    end else if (mapSel == MAP_WIDE_SPLIT) begin
      rNext = {rSix, rPair};
      gNext = {gSix, gPair};
      bNext = {bSix, bPair};
    end else begin
      rNext = {rPair, rSix};
      gNext = {gPair, gSix};
      bNext = {bPair, bSix};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      red      <= '0;
      green    <= '0;
      blue     <= '0;
      hSync    <= 1'b0;
      vSync    <= 1'b0;
      dataEn   <= 1'b0;
      pixValid <= 1'b0;
      ctlErr   <= 1'b0;
    end else begin
      pixValid <= strobes.emit;
      if (strobes.sample) begin
        red    <= rNext;
        green  <= gNext;
        blue   <= bNext;
        hSync  <= hsBit;
        vSync  <= vsBit;
        dataEn <= deBit;
      end
      if (strobes.emit && wideMode && spareBit) ctlErr <= 1'b1;
    end
  end

  AST_VALID_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> !pixValid); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ctlErr |=> ctlErr); // R9
  AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && ($past(mapSel) == MAP_NARROW)) |->
      (red[7:6] == 2'b00 && green[7:6] == 2'b00 && blue[7:6] == 2'b00)); // R5
endmodule

// File: rtl/lvds_deser.sv
module lvds_deser
  import lvds_deser_pkg::*;
#(
  parameter int LOCK_COUNT = 4,
  parameter int DROP_COUNT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LANES-1:0]   dataLanes,
  input  logic               clkLane,
  input  logic [1:0]         mapSel,
  output logic [COLOR_W-1:0] red,
  output logic [COLOR_W-1:0] green,
  output logic [COLOR_W-1:0] blue,
  output logic               hSync,
  output logic               vSync,
  output logic               dataEn,
  output logic               pixValid,
  output logic               locked,
  output logic               ctlErr
);
  ctlStrobes_t strobes;
  logic        patternMatch;

  lvds_deser_ctrl #(
    .LOCK_COUNT(LOCK_COUNT),
    .DROP_COUNT(DROP_COUNT)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .patternMatch(patternMatch),
    .strobes     (strobes),
    .locked      (locked)
  );

  lvds_deser_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .dataLanes   (dataLanes),
    .clkLane     (clkLane),
    .mapSel      (mapSel),
    .strobes     (strobes),
    .patternMatch(patternMatch),
    .red         (red),
    .green       (green),
    .blue        (blue),
    .hSync       (hSync),
    .vSync       (vSync),
    .dataEn      (dataEn),
    .pixValid    (pixValid),
    .ctlErr      (ctlErr)
  );

  AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> locked); // R3
endmodule

// File: tb/lvds_deser_test.sv
module lvds_deser_test;
  localparam int CLK_PERIOD      = 10;
  localparam int WATCHDOG_CYCLES = 50000;
  localparam logic [6:0] GOOD_CLK = 7'b1100011;
  localparam logic [6:0] BAD_CLK  = 7'b0000000;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] dataLanes;
  logic       clkLane;
  logic [1:0] mapSel;
  logic [7:0] red, green, blue;
  logic       hSync, vSync, dataEn, pixValid, locked, ctlErr;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  int capCount = 0;
  logic [7:0] capR [64];
  logic [7:0] capG [64];
  logic [7:0] capB [64];
  logic [2:0] capCtl [64];

  always #(CLK_PERIOD / 2) clk = ~clk;

  lvds_deser uut (
    .clk(clk), .rstN(rstN), .dataLanes(dataLanes), .clkLane(clkLane), .mapSel(mapSel),
    .red(red), .green(green), .blue(blue), .hSync(hSync), .vSync(vSync),
    .dataEn(dataEn), .pixValid(pixValid), .locked(locked), .ctlErr(ctlErr)
  );

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG_CYCLES) begin
      checks++;
      failures++;
      $display("FAIL R3 watchdog: actual=timeout expected=completion");
      finishRun();
    end
  end

  always @(negedge clk) begin
    if (rstN && pixValid && capCount < 64) begin
      capR[capCount]   = red;
      capG[capCount]   = green;
      capB[capCount]   = blue;
      capCtl[capCount] = {dataEn, vSync, hSync};
      capCount++;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pixR(int i, int seed);
    return 8'((seed + i * 37) & 255);
  endfunction
  function automatic logic [7:0] pixG(int i, int seed);
    return 8'((seed * 3 + i * 91 + 5) & 255);
  endfunction
  function automatic logic [7:0] pixB(int i, int seed);
    return 8'(~((seed + i * 17) & 255));
  endfunction
  function automatic logic [2:0] pixCtl(int i);
    return {(i % 3) != 0, i[1], i[0]}; // {de, vs, hs}
  endfunction
  function automatic logic [7:0] expColor(logic [7:0] c);
    return (mapSel == 2'b00) ? {2'b00, c[5:0]} : c;
  endfunction

  task automatic sendPixel(int i, int seed, logic ctl3, logic [6:0] clkWord);
    logic [7:0] r, g, b;
    logic [5:0] rA, gA, bA;
    logic [1:0] rL, gL, bL;
    logic [2:0] ctl;
    logic [6:0] w0, w1, w2, w3;
    r = pixR(i, seed); g = pixG(i, seed); b = pixB(i, seed); ctl = pixCtl(i);
    if (mapSel == 2'b01) begin
      rA = r[7:2]; gA = g[7:2]; bA = b[7:2]; rL = r[1:0]; gL = g[1:0]; bL = b[1:0];
    end else begin
      rA = r[5:0]; gA = g[5:0]; bA = b[5:0]; rL = r[7:6]; gL = g[7:6]; bL = b[7:6];
    end
    // bit s of each word is slot s
    w0[0] = gA[0];
    for (int s = 1; s < 7; s++) w0[s] = rA[6 - s];
    w1[0] = bA[1]; w1[1] = bA[0];
    for (int s = 2; s < 7; s++) w1[s] = gA[7 - s];
    w2[0] = ctl[2]; w2[1] = ctl[1]; w2[2] = ctl[0];
    for (int s = 3; s < 7; s++) w2[s] = bA[8 - s];
    if (mapSel == 2'b00) w3 = 7'((i * 45 + seed) | 1); // noise, slot 0 set
    else w3 = {rL[0], rL[1], gL[0], gL[1], bL[0], bL[1], ctl3};
    for (int s = 0; s < 7; s++) begin
      @(negedge clk);
      dataLanes = {w3[s], w2[s], w1[s], w0[s]};
      clkLane   = clkWord[s];
    end
  endtask

  task automatic idleBits(int n);
    repeat (n) begin
      @(negedge clk);
      dataLanes = '0;
      clkLane   = 1'b0;
    end
  endtask

  task automatic doReset(logic [1:0] mode);
    @(negedge clk);
    rstN = 1'b0; dataLanes = '0; clkLane = 1'b0; mapSel = mode;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    capCount = 0;
  endtask

  task automatic testResetState();
    @(negedge clk);
    rstN = 1'b0; dataLanes = '1; clkLane = 1'b1; mapSel = 2'b01;
    repeat (3) @(negedge clk);
    check("R1 locked", 32'(locked), 0);
    check("R1 pixValid", 32'(pixValid), 0);
    check("R1 ctlErr", 32'(ctlErr), 0);
    check("R1 colours", {8'h0, red, green, blue}, 0);
    check("R1 controls", {29'h0, dataEn, vSync, hSync}, 0);
  endtask

  // Aligned stream of n pixels; pixels 3..n-1 (0-based) must come out.
  task automatic streamTest(string tag, logic [1:0] mode, int n, int seed);
    doReset(mode);
    for (int i = 0; i < n; i++) sendPixel(i, seed, 1'b0, GOOD_CLK);
    idleBits(3);
    check({"R2 lock ", tag}, 32'(locked), 1);
    check({"R3 strobe count ", tag}, 32'(capCount), 32'(n - 3));
    for (int j = 0; j < capCount && j + 3 < n; j++) begin
      check({tag, " colour"}, {8'h0, capR[j], capG[j], capB[j]},
            {8'h0, expColor(pixR(j + 3, seed)), expColor(pixG(j + 3, seed)),
             expColor(pixB(j + 3, seed))});
      check({"R8 controls ", tag}, 32'(capCtl[j]), 32'(pixCtl(j + 3)));
    end
    if (mode == 2'b00) check("R9 narrow ignores lane 3", 32'(ctlErr), 0);
  endtask

  task automatic lockTimingTest();
    doReset(2'b10);
    for (int i = 0; i < 3; i++) sendPixel(i, 9, 1'b0, GOOD_CLK);
    idleBits(3);
    check("R2 three patterns not enough", 32'(locked), 0);
    check("R3 no strobe while unlocked", 32'(capCount), 0);
  endtask

  task automatic dropTest();
    doReset(2'b10);
    for (int i = 0; i < 5; i++) sendPixel(i, 4, 1'b0, GOOD_CLK);
    sendPixel(5, 4, 1'b0, BAD_CLK);
    sendPixel(6, 4, 1'b0, GOOD_CLK);
    idleBits(3);
    check("R4 single miss keeps lock", 32'(locked), 1);
    check("R4 single miss strobes", 32'(capCount), 4);

    doReset(2'b10);
    for (int i = 0; i < 5; i++) sendPixel(i, 4, 1'b0, GOOD_CLK);
    sendPixel(5, 4, 1'b0, BAD_CLK);
    sendPixel(6, 4, 1'b0, BAD_CLK);
    idleBits(3);
    check("R4 two misses drop lock", 32'(locked), 0);
    check("R4 second miss not strobed", 32'(capCount), 3);

    doReset(2'b10);
    for (int i = 0; i < 5; i++) sendPixel(i, 4, 1'b0, GOOD_CLK);
    sendPixel(5, 4, 1'b0, BAD_CLK);
    sendPixel(6, 4, 1'b0, BAD_CLK);
    for (int i = 7; i < 10; i++) sendPixel(i, 4, 1'b0, GOOD_CLK);
    idleBits(3);
    check("R4 relock needs four", 32'(locked), 0);
    check("R4 no strobe before relock", 32'(capCount), 3);

    doReset(2'b10);
    for (int i = 0; i < 5; i++) sendPixel(i, 4, 1'b0, GOOD_CLK);
    sendPixel(5, 4, 1'b0, BAD_CLK);
    sendPixel(6, 4, 1'b0, BAD_CLK);
    for (int i = 7; i < 11; i++) sendPixel(i, 4, 1'b0, GOOD_CLK);
    idleBits(3);
    check("R4 relock after four", 32'(locked), 1);
    check("R4 strobe after relock", 32'(capCount), 4);
    check("R4 relock pixel", {8'h0, capR[3], capG[3], capB[3]},
          {8'h0, pixR(10, 4), pixG(10, 4), pixB(10, 4)});
  endtask

  task automatic realignTest();
    doReset(2'b01);
    for (int i = 0; i < 2; i++) sendPixel(i, 21, 1'b0, GOOD_CLK);
    idleBits(3);
    for (int i = 2; i < 8; i++) sendPixel(i, 21, 1'b0, GOOD_CLK);
    idleBits(3);
    check("R10 realigned lock", 32'(locked), 1);
    check("R10 realigned strobes", 32'(capCount), 3);
    check("R10 first realigned pixel", {8'h0, capR[0], capG[0], capB[0]},
          {8'h0, pixR(5, 21), pixG(5, 21), pixB(5, 21)});
  endtask

  task automatic spareBitTest();
    doReset(2'b10);
    for (int i = 0; i < 6; i++) sendPixel(i, 2, (i < 3), GOOD_CLK);
    idleBits(3);
    check("R9 unstrobed spare bit ignored", 32'(ctlErr), 0);

    doReset(2'b01);
    for (int i = 0; i < 6; i++) sendPixel(i, 2, (i == 3), GOOD_CLK);
    idleBits(3);
    check("R9 spare bit sets sticky flag", 32'(ctlErr), 1);
    check("R9 pixels still strobed", 32'(capCount), 3);
  endtask

  initial begin
    rstN = 1'b0; dataLanes = '0; clkLane = 1'b0; mapSel = 2'b00;
    testResetState();
    streamTest("R5 narrow", 2'b00, 9, 3);
    streamTest("R6 split", 2'b01, 9, 77);
    streamTest("R7 extended", 2'b10, 9, 140);
    streamTest("R7 extended alt", 2'b11, 7, 201);
    lockTimingTest();
    dropTest();
    realignTest();
    spareBitTest();
    finishRun();
  end
endmodule